// File: doc/BRIEF.md
# Low-Power Entry and Exit Sequencer for a Clock Generator

This block decides when a multi-output clock generator may go to sleep and when it may run again. A request pin, active low and not tied to any clock, asks for sleep. The sequencer samples it through a filtered synchronizer. It then closes every output gate in a safe order. The bank of masked outputs closes only on a falling edge of the internal processor-rate clock. The reference output closes only while its own level is low. Only after all gates are shut does it stop the VCO and the crystal oscillator.

On release it restarts the oscillator first and waits for that oscillator to produce a rising edge. It then enables the VCO and counts a programmable number of reference-clock rising edges. Finally it reopens every gate together on a rising edge of the processor-rate clock, so no shortened first pulse leaves the chip. While running, each masked output follows its own enable bit from configuration. The block outputs only gate enables and oscillator controls. It produces no clocks of its own; the two clock levels it watches come in as inputs.

Top module: `pwrdn_seq`

## Requirements
- R1: During and right after reset the block is running: every bit of `out_gate` is 1, and `ref_gate`, `fix_gate`, `vco_en` and `osc_en` are all 1.
- R2: A low level on `pd_n_async` that is sampled on fewer than `SYNC_DEPTH` consecutive rising edges of `clk` is ignored. `fix_gate` stays 1 and the sequencer stays running.
- R3: A low level on `pd_n_async` that is first sampled at rising edge e1 and held clears `fix_gate` at edge e(SYNC_DEPTH+2), and not before. The fixed-rate output closes as soon as the request is accepted.
- R4: Once sleep has been requested, `out_gate` keeps its value until an edge at which `cpu_lvl` is sampled 0 after being sampled 1 on the edge before. At that edge every bit clears.
- R5: `vco_en` and `osc_en` fall only when `out_gate` is all zero and both `ref_gate` and `fix_gate` are 0. They stay 0 while the request is held.
- R6: `ref_gate` clears only at an edge where `ref_lvl` is sampled 0. While `ref_lvl` stays high the gate may stay open for several cycles after the request.
- R7: On wake, `fix_gate`, `ref_gate` and `out_gate` reopen on the same edge, and only at an edge where `cpu_lvl` is sampled 1 after being sampled 0 on the edge before.
- R8: Between the edge that raises `vco_en` and the edge that reopens the outputs, at least `SETTLE_CYC` rising edges of `ref_lvl` are sampled.
- R9: While running, `out_gate` equals `out_mask` as sampled on the previous edge. A 1 in bit i enables output i, and a 0 holds that output low.
- R10: If the request returns during oscillator start or settling, `vco_en` and `osc_en` fall within `SYNC_DEPTH+2` edges. No output gate opens during that time.
- R11: The number of `clk` cycles from release of `pd_n_async` to the reopening of the outputs is bounded by a fixed limit. The limit is `SYNC_DEPTH+8` plus `(SETTLE_CYC+2)` reference periods plus one processor-clock period. The default of 40000 reference edges keeps the delay under 3 ms at 14.318 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_n_async | input | 1 | Sleep request, active low, asynchronous |
| cpu_lvl | input | 1 | Level of the internal processor-rate clock |
| ref_lvl | input | 1 | Level of the reference (oscillator) clock |
| out_mask | input | N_OUT | Per-output enable from configuration, 1 = enabled |
| out_gate | output | N_OUT | Gate enables for the masked output bank |
| ref_gate | output | 1 | Gate enable for the reference output |
| fix_gate | output | 1 | Gate enable for the fixed-rate (48 MHz class) outputs |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
A sequencer state that is wrong shows up at the ports within a few clocks. A state that leaves RUN too early drops `fix_gate` ahead of the `SYNC_DEPTH+2` edge. A state that leaves FREEZE without a processor-clock fall clears `out_gate` on an edge with no falling `cpu_lvl`. A wrong order in the drain states lowers `vco_en` while a gate is still open. A settle counter that is wrong or never clears either reopens the outputs before `SETTLE_CYC` reference rises or exceeds the wake bound.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_FREEZE    = 3'd1,
        ST_DRAIN_REF = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_WAKE_OSC  = 3'd4,
        ST_SETTLE    = 3'd5
    } seq_state_t;

    // Controls for the oscillator, the VCO and the two ungated-by-mask outputs
    typedef struct packed {
        logic osc;
        logic vco;
        logic refo;
        logic fixo;
    } rail_t;

    localparam rail_t RAIL_ALL_ON = '{osc: 1'b1, vco: 1'b1, refo: 1'b1, fixo: 1'b1};

    function automatic logic in_wake(seq_state_t s);
        return (s == ST_WAKE_OSC) || (s == ST_SETTLE);
    endfunction

    // Rail values that go with the state about to be entered.
    // The reference gate may only close while the reference level is low.
    function automatic rail_t rail_next(seq_state_t nxt, logic refo_q, logic ref_lvl);
        rail_t r;
        r.fixo = (nxt == ST_RUN);
        r.refo = (nxt == ST_RUN) || (refo_q && ref_lvl);
        r.vco  = (nxt == ST_RUN) || (nxt == ST_FREEZE) ||
                 (nxt == ST_DRAIN_REF) || (nxt == ST_SETTLE);
        r.osc  = (nxt != ST_SLEEP);
        return r;
    endfunction

    function automatic int unsigned count_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pd_filter.sv
module pd_filter #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n_async,
    output logic pd_req
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[DEPTH-2:0], pd_n_async};
    end

    // Hysteresis: set only when every stage is low, clear only when every stage is high
    always_ff @(posedge clk) begin
        if (rst)                pd_req <= 1'b0;
        else if (chain == '0)   pd_req <= 1'b1;
        else if (chain == '1)   pd_req <= 1'b0;
    end
endmodule

// File: rtl/edge_tap.sv
module edge_tap #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign hit = lvl & ~prev;
        end else begin : g_fall
            assign hit = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/settle_timer.sv
module settle_timer
    import pdseq_pkg::*;
#(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int CW = count_width(CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    logic [CW-1:0] cnt;

    assign done = (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear)      cnt <= '0;
        else if (step && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
    import pdseq_pkg::*;
#(
    parameter int N_OUT      = 24,
    parameter int SYNC_DEPTH = 3,
    parameter int SETTLE_CYC = 40000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_n_async,
    input  logic             cpu_lvl,
    input  logic             ref_lvl,
    input  logic [N_OUT-1:0] out_mask,
    output logic [N_OUT-1:0] out_gate,
    output logic             ref_gate,
    output logic             fix_gate,
    output logic             vco_en,
    output logic             osc_en
);
    logic       pd_req;
    logic       cpu_rise, cpu_fall, ref_rise;
    logic       settle_done;
    seq_state_t st_q, st_d;
    rail_t      rail_q, rail_d;
    logic [N_OUT-1:0] gate_d;

    pd_filter #(.DEPTH(SYNC_DEPTH)) u_filt (
        .clk(clk), .rst(rst), .pd_n_async(pd_n_async), .pd_req(pd_req)
    );

    edge_tap #(.RISING(1'b1)) u_cpu_rise (
        .clk(clk), .rst(rst), .lvl(cpu_lvl), .hit(cpu_rise)
    );
    edge_tap #(.RISING(1'b0)) u_cpu_fall (
        .clk(clk), .rst(rst), .lvl(cpu_lvl), .hit(cpu_fall)
    );
    edge_tap #(.RISING(1'b1)) u_ref_rise (
        .clk(clk), .rst(rst), .lvl(ref_lvl), .hit(ref_rise)
    );

    settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .clear(st_q != ST_SETTLE),
        .step(ref_rise), .done(settle_done)
    );

    // Sequencing
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:       if (pd_req)     st_d = ST_FREEZE;
            ST_FREEZE:    if (cpu_fall)   st_d = ST_DRAIN_REF;
            ST_DRAIN_REF: if (!rail_q.refo) st_d = ST_SLEEP;
            ST_SLEEP:     if (!pd_req)    st_d = ST_WAKE_OSC;
            ST_WAKE_OSC: begin
                if (pd_req)        st_d = ST_SLEEP;
                else if (ref_rise) st_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (pd_req)                       st_d = ST_SLEEP;
                else if (settle_done && cpu_rise) st_d = ST_RUN;
            end
            default: st_d = ST_SLEEP;
        endcase
    end

    // Masked output bank: follows the mask in RUN, freezes on a CPU fall,
    // reopens only on the CPU rise that ends settling
    always_comb begin
        unique case (st_q)
            ST_RUN:    gate_d = out_mask;
            ST_FREEZE: gate_d = cpu_fall ? '0 : out_gate;
            ST_SETTLE: gate_d = (st_d == ST_RUN) ? out_mask : '0;
            default:   gate_d = '0;
        endcase
    end

    assign rail_d = rail_next(st_d, rail_q.refo, ref_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            rail_q <= RAIL_ALL_ON;
        end else begin
            st_q   <= st_d;
            rail_q <= rail_d;
        end
    end

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_gate
            always_ff @(posedge clk) begin
                if (rst) out_gate[i] <= 1'b1;
                else     out_gate[i] <= gate_d[i];
            end
        end
    endgenerate

    assign ref_gate = rail_q.refo;
    assign fix_gate = rail_q.fixo;
    assign vco_en   = rail_q.vco;
    assign osc_en   = rail_q.osc;
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk
    import pdseq_pkg::*;
#(
    parameter int N_OUT      = 24,
    parameter int SETTLE_CYC = 40000
) (
    input logic             clk,
    input logic             rst,
    input seq_state_t       st,
    input logic             pd_req,
    input logic             cpu_lvl,
    input logic             ref_lvl,
    input logic [N_OUT-1:0] out_gate,
    input logic             ref_gate,
    input logic             fix_gate,
    input logic             vco_en,
    input logic             osc_en
);
    logic        ref_d;
    int unsigned rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d <= 1'b0;
            rises <= 0;
        end else begin
            ref_d <= ref_lvl;
            if (st != ST_SETTLE)
                rises <= 0;
            else if (ref_lvl && !ref_d && rises < SETTLE_CYC + 4)
                rises <= rises + 1;
        end
    end

    p_freeze_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN_REF && $past(st) == ST_FREEZE)
        |-> (out_gate == '0 && !$past(cpu_lvl) && $past(cpu_lvl, 2)));

    p_rails_after_gates_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(vco_en) || $fell(osc_en))
        |-> (out_gate == '0 && !ref_gate && !fix_gate));

    p_ref_closes_low_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_gate) |-> !$past(ref_lvl));

    p_reopen_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && $past(st) == ST_SETTLE)
        |-> ($past(cpu_lvl) && !$past(cpu_lvl, 2) && fix_gate && ref_gate));

    p_settle_count_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && $past(st) == ST_SETTLE) |-> ($past(rises) >= SETTLE_CYC));

    p_abort_wake_r10: assert property (@(posedge clk) disable iff (rst)
        (pd_req && in_wake(st)) |=> (st == ST_SLEEP && !vco_en && !osc_en && out_gate == '0));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.N_OUT(N_OUT), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst(rst), .st(st_q), .pd_req(pd_req),
    .cpu_lvl(cpu_lvl), .ref_lvl(ref_lvl), .out_gate(out_gate),
    .ref_gate(ref_gate), .fix_gate(fix_gate), .vco_en(vco_en), .osc_en(osc_en)
);

// File: tb/sim_pwrdn_seq.sv
module sim_pwrdn_seq;
    localparam int NO = 8;
    localparam int SD = 3;
    localparam int SC = 6;
    localparam int WD = 150000;

    logic clk = 1'b0, rst = 1'b1, pd_n = 1'b1, cpu_lvl = 1'b0, ref_lvl = 1'b0;
    logic [NO-1:0] mask = '0;
    logic [NO-1:0] out_gate;
    logic ref_gate, fix_gate, vco_en, osc_en;

    int cpu_half = 2, ref_half = 3, cpu_cnt = 0, ref_cnt = 0;
    int tests = 0, fails = 0, cyc = 0, rr = 0;
    logic cpu_s1 = 0, cpu_s2 = 0, ref_s1 = 0, ref_s2 = 0;
    logic [NO-1:0] mask_s1 = '0, out_p = '1;
    logic fix_p = 1, vco_p = 1, refg_p = 1;

    always #10 clk = ~clk;

    pwrdn_seq #(.N_OUT(NO), .SYNC_DEPTH(SD), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst(rst), .pd_n_async(pd_n), .cpu_lvl(cpu_lvl), .ref_lvl(ref_lvl),
        .out_mask(mask), .out_gate(out_gate), .ref_gate(ref_gate), .fix_gate(fix_gate),
        .vco_en(vco_en), .osc_en(osc_en)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wake_limit(int ch, int rh);
        return SD + 8 + (SC + 2) * 2 * rh + 2 * ch;
    endfunction

    // Clock-level models: stopped low while their source is disabled
    always @(negedge clk) begin
        if (!vco_en) begin cpu_lvl <= 1'b0; cpu_cnt <= 0; end
        else if (cpu_cnt + 1 >= cpu_half) begin cpu_cnt <= 0; cpu_lvl <= ~cpu_lvl; end
        else cpu_cnt <= cpu_cnt + 1;
        if (!osc_en) begin ref_lvl <= 1'b0; ref_cnt <= 0; end
        else if (ref_cnt + 1 >= ref_half) begin ref_cnt <= 0; ref_lvl <= ~ref_lvl; end
        else ref_cnt <= ref_cnt + 1;
    end

    always @(posedge clk) begin
        cpu_s2 <= cpu_s1; cpu_s1 <= cpu_lvl;
        ref_s2 <= ref_s1; ref_s1 <= ref_lvl;
        mask_s1 <= mask;
        cyc <= cyc + 1;
        if (cyc == WD) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Edge monitors
    always @(negedge clk) begin
        if (!rst) begin
            if (out_p != '0 && out_gate == '0 && !fix_p && !fix_gate)
                chk(!cpu_s1 && cpu_s2, "R4 gates closed off a cpu fall", {cpu_s2, cpu_s1}, 2);
            if (vco_p && !vco_en)
                chk(out_gate == '0 && !ref_gate && !fix_gate, "R5 rails off with gate open",
                    {out_gate, ref_gate, fix_gate}, 0);
            if (refg_p && !ref_gate)
                chk(!ref_s1, "R6 ref gate closed while ref high", ref_s1, 0);
            if (!fix_p && fix_gate) begin
                chk(cpu_s1 && !cpu_s2 && ref_gate, "R7 reopen not on cpu rise",
                    {cpu_s2, cpu_s1, ref_gate}, 3);
                chk(rr >= SC, "R8 settle edges", rr, SC);
                chk(out_gate == mask_s1, "R9 mask at reopen", out_gate, mask_s1);
            end
            if (fix_p && out_gate != mask_s1)
                chk(1'b0, "R9 running gate vs mask", out_gate, mask_s1);
            if (!vco_p && vco_en) rr <= 0;
            else if (ref_s1 && !ref_s2) rr <= rr + 1;
        end
        out_p <= out_gate; fix_p <= fix_gate; vco_p <= vco_en; refg_p <= ref_gate;
    end

    task automatic short_pulse();
        int w = 1 + $urandom_range(0, SD - 2);
        bit stay = 1'b1;
        pd_n <= 1'b0;
        repeat (w) @(negedge clk);
        pd_n <= 1'b1;
        repeat (SD + 6) begin
            @(negedge clk);
            if (!fix_gate || !vco_en) stay = 1'b0;
        end
        chk(stay, "R2 short request honoured", fix_gate, 1);
    endtask

    task automatic enter_sleep();
        pd_n <= 1'b0;
        repeat (SD + 1) @(negedge clk);
        chk(fix_gate == 1'b1, "R3 fixed gate dropped early", fix_gate, 1);
        @(negedge clk);
        chk(fix_gate == 1'b0, "R3 fixed gate not dropped", fix_gate, 0);
        while (vco_en) @(negedge clk);
        repeat ($urandom_range(3, 20)) @(negedge clk);
        chk(!vco_en && !osc_en && out_gate == '0 && !ref_gate, "R5 sleep not held",
            {vco_en, osc_en, ref_gate}, 0);
    endtask

    task automatic wake();
        int n = 0;
        int lim = wake_limit(cpu_half, ref_half);
        pd_n <= 1'b1;
        while (!fix_gate) begin @(negedge clk); n++; end
        chk(n <= lim, "R11 wake latency", n, lim);
    endtask

    task automatic abort_wake();
        bit quiet = 1'b1;
        pd_n <= 1'b1;
        while (!vco_en) @(negedge clk);
        pd_n <= 1'b0;
        repeat (SD + 2) begin
            @(negedge clk);
            if (fix_gate || out_gate != '0) quiet = 1'b0;
        end
        chk(!vco_en && !osc_en && quiet, "R10 abort during settle", {vco_en, osc_en, quiet}, 1);
        repeat (5) @(negedge clk);
        wake();
    endtask

    initial begin
        void'($urandom(32'd2024));
        mask = NO'($urandom);
        repeat (3) @(negedge clk);
        chk(out_gate == '1, "R1 reset gates", out_gate, {NO{1'b1}});
        chk(fix_gate && ref_gate && vco_en && osc_en, "R1 reset rails",
            {fix_gate, ref_gate, vco_en, osc_en}, 15);
        rst <= 1'b0;
        repeat (6) @(negedge clk);
        for (int it = 0; it < 12; it++) begin
            cpu_half = 1 + $urandom_range(0, 2);
            ref_half = 2 + $urandom_range(0, 2);
            mask <= NO'($urandom);
            repeat (4 + $urandom_range(0, 6)) @(negedge clk);
            short_pulse();
            enter_sleep();
            if (it % 3 == 1) abort_wake();
            else wake();
            repeat (5) @(negedge clk);
        end
        mask <= '0;
        repeat (3) @(negedge clk);
        enter_sleep();
        wake();
        @(negedge clk);
        chk(out_gate == '0, "R9 fully masked bank stays low", out_gate, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule